// File: doc/BRIEF.md
# Serial Master Readout Port

This block sends a converter's 16-bit result out on a three-wire serial link while acting as the link master. It makes its own serial clock from the system clock, frames each word with a sync strobe, and shifts the word out most significant bit first. The conversion sequencer gives it the result word, a one-cycle done pulse, a one-cycle start pulse and its own busy level.

Two read orderings are supported. In after-conversion reading, a frame starts on the done pulse and carries the word that just finished. The busy output is stretched until that frame has closed. The serial clock rate can then be lowered in four binary steps. In during-conversion reading, a frame starts on the start pulse of the next conversion and carries the word held from the previous one, always at the fastest rate. The active levels of the sync strobe and the clock can each be inverted. Raising the chip select releases all three link outputs.

Top module: `smr_port`

## Requirements
- R1: Each frame gives exactly 16 rising edges of the normalised clock (raw level XOR `sclk_inv`). `sdout` carries the word most significant bit first, is valid at each rising edge, and changes only after a falling edge.
- R2: With `rd_during` = 0, a `conv_done` pulse starts a frame carrying `result` from that same cycle. `busy` is high from that cycle until the sync strobe goes inactive.
- R3: With `rd_during` = 0, every half period of the serial clock lasts BASE_HALF << `div_sel` system cycles (codes 0,1,2,3 give 2,4,8,16 cycles at the default). The code is sampled when the frame starts, and later changes to it have no effect on that frame.
- R4: With `rd_during` = 1, a `conv_start` pulse starts a frame carrying the word latched by the most recent earlier `conv_done`. `div_sel` is ignored and the half period is BASE_HALF cycles. When `conv_start` and `conv_done` fall in the same cycle, the frame carries the older word and the new word is kept for the next frame.
- R5: With `sync_inv` = 0 the sync strobe is high during a frame and low otherwise. With `sync_inv` = 1 it is low during a frame and high otherwise.
- R6: The raw serial clock idles low outside frames, and `sclk` is the raw clock XOR `sclk_inv`, so with `sclk_inv` = 1 it idles high.
- R7: The first clock transition comes exactly LEAD_CYC + half-period cycles after the sync strobe goes active. The strobe goes inactive exactly TRAIL_CYC cycles after the last clock transition.
- R8: Start or done pulses that arrive while a frame is in progress start no further frame.
- R9: While `cs_n` is high, `sclk`, `sync` and `sdout` are high impedance.
- R10: After reset, with `cs_n` low and both polarity inputs low, `sync`, `sclk` and `sdout` are low and `busy` follows `conv_busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, low enables the link outputs |
| rd_during | input | 1 | 1: read during next conversion, 0: read after conversion |
| div_sel | input | 2 | Clock slow-down code for after-conversion reading |
| sync_inv | input | 1 | 1 makes the sync strobe active low |
| sclk_inv | input | 1 | 1 inverts the serial clock |
| conv_start | input | 1 | One-cycle pulse: a conversion begins |
| conv_done | input | 1 | One-cycle pulse: `result` is valid |
| conv_busy | input | 1 | Busy level from the sequencer |
| result | input | DATA_W | Conversion result |
| busy | output | 1 | Busy seen by the host, stretched over after-conversion frames |
| sclk | output | 1 | Serial clock |
| sync | output | 1 | Frame strobe |
| sdout | output | 1 | Serial data |

## Verification
In during-conversion reading, a frame is loaded from the holding register on `conv_start`, and the same register is rewritten on `conv_done`. The two can land in the same cycle. The bench pulses both together with a fresh word on `result`. It expects the frame to carry the word from the earlier conversion, and the following frame to carry the fresh one. Start and done pulses are also given in the middle of frames, and the bench expects its scoreboard queue to hold exactly one entry per frame seen on the wires.

// File: rtl/smr_pkg.sv
package smr_pkg;

  typedef enum logic [1:0] {FR_IDLE, FR_LEAD, FR_SHIFT, FR_TRAIL} fr_state_t;

  // Half-period length of the serial clock in system cycles.
  function automatic int unsigned smr_half_cycles(input int unsigned base,
                                                  input logic [1:0] div,
                                                  input logic during);
    if (during) return base;
    return base << div;
  endfunction

endpackage

// File: rtl/smr_sclk_gen.sv
module smr_sclk_gen #(
  parameter int DATA_W = 16,
  parameter int HALF_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half_len,
  output logic              sclk_raw,
  output logic              rise_ev,
  output logic              fall_ev,
  output logic              last_ev
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EC_W  = $clog2(EDGES);

  logic [HALF_W-1:0] hc;
  logic [EC_W-1:0]   ec;
  logic              tick;

  assign tick    = run && (hc == half_len - HALF_W'(1));
  assign rise_ev = tick && !sclk_raw;
  assign fall_ev = tick && sclk_raw;
  assign last_ev = fall_ev && (ec == EC_W'(EDGES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc       <= '0;
      ec       <= '0;
      sclk_raw <= 1'b0;
    end else if (!run) begin
      hc       <= '0;
      ec       <= '0;
      sclk_raw <= 1'b0;
    end else if (tick) begin
      hc       <= '0;
      ec       <= ec + 1'b1;
      sclk_raw <= ~sclk_raw;
    end else begin
      hc <= hc + 1'b1;
    end
  end
endmodule

// File: rtl/smr_shifter.sv
module smr_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift,
  output logic              msb
);
  logic [DATA_W-1:0] sr;

  assign msb = sr[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= load_val;
    else if (shift) sr <= {sr[DATA_W-2:0], 1'b0};
  end
endmodule

// File: rtl/smr_port.sv
module smr_port
  import smr_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int BASE_HALF = 2,
  parameter int LEAD_CYC  = 3,
  parameter int TRAIL_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_during,
  input  logic [1:0]        div_sel,
  input  logic              sync_inv,
  input  logic              sclk_inv,
  input  logic              conv_start,
  input  logic              conv_done,
  input  logic              conv_busy,
  input  logic [DATA_W-1:0] result,
  output logic              busy,
  output logic              sclk,
  output logic              sync,
  output logic              sdout
);
  localparam int HALF_W   = $clog2(BASE_HALF * 8 + 1);
  localparam int WAIT_MAX = (LEAD_CYC > TRAIL_CYC) ? LEAD_CYC : TRAIL_CYC;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

  fr_state_t         st;
  logic [WAIT_W-1:0] wt;
  logic [HALF_W-1:0] half_q;
  logic [DATA_W-1:0] hold_q;
  logic              frame_after;

  // Named internal events
  logic              start_after, start_during, frame_go, frame_active;
  logic              shift_run, sclk_raw, rise_ev, fall_ev, last_ev, sr_msb;
  logic [DATA_W-1:0] load_val;

  assign start_after  = conv_done && !rd_during;
  assign start_during = conv_start && rd_during;
  assign frame_active = (st != FR_IDLE);
  assign frame_go     = !frame_active && (start_after || start_during);
  assign shift_run    = (st == FR_SHIFT);
  assign load_val     = start_after ? result : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hold_q <= '0;
    else if (conv_done) hold_q <= result;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= FR_IDLE;
      wt          <= '0;
      half_q      <= HALF_W'(BASE_HALF);
      frame_after <= 1'b0;
    end else begin
      unique case (st)
        FR_IDLE: if (frame_go) begin
          st          <= FR_LEAD;
          wt          <= '0;
          half_q      <= HALF_W'(smr_half_cycles(BASE_HALF, div_sel, rd_during));
          frame_after <= start_after;
        end
        FR_LEAD: begin
          wt <= wt + 1'b1;
          if (wt == WAIT_W'(LEAD_CYC - 1)) st <= FR_SHIFT;
        end
        FR_SHIFT: if (last_ev) begin
          st <= FR_TRAIL;
          wt <= '0;
        end
        FR_TRAIL: begin
          wt <= wt + 1'b1;
          if (wt == WAIT_W'(TRAIL_CYC - 1)) st <= FR_IDLE;
        end
        default: st <= FR_IDLE;
      endcase
    end
  end

  smr_sclk_gen #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_sclk_gen (
    .clk(clk), .rst_n(rst_n), .run(shift_run), .half_len(half_q),
    .sclk_raw(sclk_raw), .rise_ev(rise_ev), .fall_ev(fall_ev), .last_ev(last_ev)
  );

  smr_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk(clk), .rst_n(rst_n), .load(frame_go), .load_val(load_val),
    .shift(fall_ev && !last_ev), .msb(sr_msb)
  );

  assign busy  = conv_busy | start_after | (frame_active & frame_after);
  assign sclk  = cs_n ? 1'bz : (sclk_raw ^ sclk_inv);
  assign sync  = cs_n ? 1'bz : (frame_active ^ sync_inv);
  assign sdout = cs_n ? 1'bz : (frame_active & sr_msb);
endmodule

// File: rtl/smr_checker.sv
module smr_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_during,
  input logic              conv_start,
  input logic              conv_done,
  input logic [DATA_W-1:0] result,
  input logic              busy,
  input logic              frame_active,
  input logic              frame_after,
  input logic              frame_go,
  input logic              start_after,
  input logic              sclk_raw,
  input logic              fall_ev,
  input logic              last_ev,
  input logic              sr_msb
);
  assert_msb_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_go && start_after) |=> (sr_msb == $past(result[DATA_W-1])));

  assert_shift_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && !fall_ev) |=> $stable(sr_msb));

  assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && frame_after) |-> busy);

  assert_trigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_active) |-> $past((conv_done && !rd_during) || (conv_start && rd_during)));

  assert_sclk_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_active |-> !sclk_raw);

  assert_trail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_ev |=> frame_active);

  assert_no_early_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_ev && !last_ev) |=> frame_active);
endmodule

bind smr_port smr_checker #(.DATA_W(DATA_W)) u_smr_chk (
  .clk(clk), .rst_n(rst_n), .rd_during(rd_during), .conv_start(conv_start),
  .conv_done(conv_done), .result(result), .busy(busy), .frame_active(frame_active),
  .frame_after(frame_after), .frame_go(frame_go), .start_after(start_after),
  .sclk_raw(sclk_raw), .fall_ev(fall_ev), .last_ev(last_ev), .sr_msb(sr_msb)
);

// File: tb/test_smr_port.sv
module test_smr_port;
  localparam int BASE  = 2;
  localparam int LEAD  = 3;
  localparam int TRAIL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0, cs_n = 1'b0, rd_during = 1'b0, sync_inv = 1'b0, sclk_inv = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic conv_start = 1'b0, conv_done = 1'b0, conv_busy = 1'b0;
  logic [15:0] result = '0;
  logic busy;
  wire  sclk_w, sync_w, sdout_w;

  pullup (sclk_w);
  pullup (sync_w);
  pullup (sdout_w);

  always #4 clk = ~clk;

  smr_port i_smr_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_during(rd_during), .div_sel(div_sel),
    .sync_inv(sync_inv), .sclk_inv(sclk_inv), .conv_start(conv_start),
    .conv_done(conv_done), .conv_busy(conv_busy), .result(result), .busy(busy),
    .sclk(sclk_w), .sync(sync_w), .sdout(sdout_w)
  );

  typedef struct { logic [15:0] data; int half; bit after; } exp_t;
  exp_t q[$];

  int n_chk = 0, n_bad = 0, frames_done = 0, n_exp = 0, cycles = 0;
  logic [15:0] hold_m = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor / scoreboard
  bit in_fr = 0, have = 0, c_prev = 0, per_bad = 0, busy_bad = 0, lead_bad = 0;
  int cyc = 0, edges = 0, bad_cyc = 0;
  logic [15:0] word = '0;
  exp_t cur;

  always @(negedge clk) begin
    if (rst_n && !cs_n) begin
      bit act, c;
      act = sync_w ^ sync_inv;
      c   = sclk_w ^ sclk_inv;
      if (!in_fr && act) begin
        in_fr = 1; cyc = 0; edges = 0; word = '0;
        per_bad = 0; busy_bad = 0; lead_bad = 0; c_prev = c;
        have = (q.size() > 0);
        if (have) cur = q[0];
        else cur = '{16'h0, BASE, 1'b0};
      end else if (in_fr) begin
        cyc++;
        if (act && cur.after && !busy) busy_bad = 1;
        if (c != c_prev) begin
          if (edges == 0) begin
            if (cyc != LEAD + cur.half) begin lead_bad = 1; bad_cyc = cyc; end
          end else if (cyc != cur.half) begin
            per_bad = 1; bad_cyc = cyc;
          end
          edges++;
          if (c) word = {word[14:0], sdout_w};
          cyc = 0;
        end
        c_prev = c;
        if (!act) begin
          in_fr = 0;
          chk(have, "R8 frame without trigger", 1, 0);
          if (have) begin
            void'(q.pop_front());
            chk(word == cur.data, "R1 word", word, cur.data);
            chk(edges == 32, "R1 edge count", edges, 32);
            chk(!per_bad, cur.after ? "R3 half period" : "R4 half period", bad_cyc, cur.half);
            chk(!lead_bad, "R7 lead", bad_cyc, LEAD + cur.half);
            chk(cyc == TRAIL, "R7 trail", cyc, TRAIL);
            if (cur.after) chk(!busy_bad, "R2 busy during frame", 0, 1);
          end
          frames_done++;
        end
      end
    end
  end

  task automatic wait_frames();
    while (frames_done < n_exp) @(negedge clk);
  endtask

  task automatic do_after(input logic [15:0] d, input bit retrig, input bit chg_div);
    repeat (4) @(negedge clk) conv_busy = 1'b1;
    @(negedge clk);
    result = d; conv_done = 1'b1; conv_busy = 1'b0; hold_m = d;
    q.push_back('{d, BASE << div_sel, 1'b1}); n_exp++;
    #1 chk(busy == 1'b1, "R2 busy at done", busy, 1);
    @(negedge clk); conv_done = 1'b0;
    if (retrig || chg_div) begin
      repeat (20) @(negedge clk);
      if (chg_div) div_sel = ~div_sel;
      if (retrig) begin
        result = 16'h1234; conv_done = 1'b1; hold_m = 16'h1234;
        @(negedge clk); conv_done = 1'b0;
      end
    end
    wait_frames();
  endtask

  task automatic do_during(input logic [15:0] d, input bit same_cycle);
    @(negedge clk);
    conv_start = 1'b1; conv_busy = 1'b1;
    q.push_back('{hold_m, BASE, 1'b0}); n_exp++;
    if (same_cycle) begin
      result = d; conv_done = 1'b1; hold_m = d;
      @(negedge clk); conv_start = 1'b0; conv_done = 1'b0; conv_busy = 1'b0;
    end else begin
      @(negedge clk); conv_start = 1'b0;
      repeat (10) @(negedge clk);
      conv_start = 1'b1;                       // stray start mid-frame (R8)
      @(negedge clk); conv_start = 1'b0;
      result = d; conv_done = 1'b1; conv_busy = 1'b0; hold_m = d;
      @(negedge clk); conv_done = 1'b0;
    end
    wait_frames();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(sync_w == 1'b0, "R10 sync idle", sync_w, 0);
    chk(sclk_w == 1'b0, "R10 sclk idle", sclk_w, 0);
    chk(sdout_w == 1'b0, "R10 sdout idle", sdout_w, 0);
    chk(busy == 1'b0, "R10 busy low", busy, 0);
    conv_busy = 1'b1; #1
    chk(busy == 1'b1, "R10 busy follows", busy, 1);
    conv_busy = 1'b0;
    // R9 release
    @(negedge clk); cs_n = 1'b1; #1
    chk(sync_w === 1'b1 && sclk_w === 1'b1 && sdout_w === 1'b1, "R9 released",
        {sync_w, sclk_w, sdout_w}, 3'b111);
    @(negedge clk); cs_n = 1'b0;
    // R2 / R3 across all divider codes
    for (int k = 0; k < 4; k++) begin
      div_sel = 2'(k);
      do_after(16'hA5C3 ^ 16'(k * 16'h1111), 1'b0, 1'b0);
    end
    div_sel = 2'd0; do_after(16'h8001, 1'b0, 1'b0);
    do_after(16'hFFFF, 1'b0, 1'b0);
    do_after(16'h0000, 1'b0, 1'b0);
    // R3 divider change mid-frame ignored
    div_sel = 2'd1; do_after(16'h3C5A, 1'b0, 1'b1);
    // R8 done pulse mid-frame ignored
    div_sel = 2'd2; do_after(16'h7E81, 1'b1, 1'b0);
    repeat (40) @(negedge clk);
    chk(frames_done == n_exp && q.size() == 0, "R8 no extra frame", frames_done, n_exp);
    // R5 / R6 inverted polarity
    sync_inv = 1'b1; sclk_inv = 1'b1; @(negedge clk);
    chk(sync_w == 1'b1, "R5 inverted sync idle", sync_w, 1);
    chk(sclk_w == 1'b1, "R6 inverted sclk idle", sclk_w, 1);
    div_sel = 2'd0; do_after(16'h4BD2, 1'b0, 1'b0);
    sync_inv = 1'b0; sclk_inv = 1'b0;
    // R4 during-conversion reading, divider ignored
    rd_during = 1'b1; div_sel = 2'd3;
    do_during(16'h0F0F, 1'b0);               // carries 16'h4BD2
    do_during(16'hC001, 1'b0);               // carries 16'h0F0F
    do_during(16'h5AA5, 1'b1);               // same cycle: carries 16'hC001
    do_during(16'h1111, 1'b0);               // carries 16'h5AA5
    repeat (40) @(negedge clk);
    chk(frames_done == n_exp && q.size() == 0, "R8 R4 frame count", frames_done, n_exp);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", frames_done, n_exp);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule